// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block gives an 8-bit processor two parallel ports of eight lines each. It also gives each port a pair of control lines that raise interrupts or drive handshakes. The processor reaches the block through three chip selects, two register-select lines, a read/write line and an E strobe. In this design E is a one-clock-wide enable inside the core clock domain. Every register transfer and every edge-detector sample happens on a clock edge where E is high.

Each port has four registers:
- a direction register, where a 1 makes a line an output;
- an output register;
- a control register;
- two read-only interrupt flags.

The two ports share one address for the direction register and the output register. Bit 2 of the port's control register chooses which of the two that address reaches. The first control line of a port only senses edges. The second control line can be an edge-sensing input, a fixed-level output, or a handshake output. Pins are split into separate input, output and output-enable vectors.

Top module: `par_io_adapter`

## Requirements
- R1: The block is selected only when cs0_i=1, cs1_i=1 and cs2_ni=0. A strobe without selection changes no register, and rdata_o is 0 when the block is not selected or rw_i=0.
- R2: Each direction bit sets the matching pin_oe bit: 1 is output, 0 is input. The output register value appears on the pin_out vector.
- R3: A data read returns the output register bit for output lines and the live pin for input lines.
- R4: The register map is as follows. rs_i=0 and rs_i=2 are the data address of port A and port B. That address reaches the direction register when control bit 2 is 0, and the output register when it is 1. rs_i=1 and rs_i=3 are the control registers of A and B. Control bits 5:0 are writable. Control bits 7 and 6 read back flag 1 and flag 2, and writes to them are ignored.
- R5: Control bit 1 picks the active edge of the first control line: 1 is rising, 0 is falling. An active edge sets flag 1.
- R6: An edge counts only if, at an earlier strobe, the line was sampled at its inactive level. A line held at its active level since reset never sets a flag.
- R7: A processor read of a port's output register (data address with bit 2 = 1) clears both flags of that port.
- R8: The irq output is low when flag 1 and enable bit 0 are both set, or when flag 2 and enable bit 3 are both set with the second line in input mode. Otherwise it is high.
- R9: Reset clears every register: all lines are inputs, both irq outputs are high, both control registers read 0, and the second control lines are not driven.
- R10: With control bit 5 = 0, the second control line is an input. Control bit 4 picks its active edge (1 is rising), and an active edge sets flag 2.
- R11: With control bits 5:4 = 11, the second control line is driven to the value of control bit 3.
- R12: With control bits 5:3 = 100, port A's second line idles high. It goes low after a read of A's output register and returns high on the next active edge of the first control line.
- R13: With control bits 5:3 = 101, the line goes low after the triggering access and returns high at the next strobe.
- R14: Port B's handshake is triggered by a write to its output register. A read of that register leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs0_i | input | 1 | Chip select, active high |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| rs_i | input | 2 | Register select |
| rw_i | input | 1 | 1 = read, 0 = write |
| e_i | input | 1 | Bus strobe, one clock wide |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pa_in_i | input | 8 | Port A pin levels |
| pa_out_o | output | 8 | Port A output register |
| pa_oe_o | output | 8 | Port A line direction |
| ca1_i | input | 1 | Port A first control line |
| ca2_i | input | 1 | Port A second control line, input side |
| ca2_out_o | output | 1 | Port A second control line, driven value |
| ca2_oe_o | output | 1 | Port A second control line, drive enable |
| irq_a_no | output | 1 | Port A interrupt, active low |
| pb_in_i | input | 8 | Port B pin levels |
| pb_out_o | output | 8 | Port B output register |
| pb_oe_o | output | 8 | Port B line direction |
| cb1_i | input | 1 | Port B first control line |
| cb2_i | input | 1 | Port B second control line, input side |
| cb2_out_o | output | 1 | Port B second control line, driven value |
| cb2_oe_o | output | 1 | Port B second control line, drive enable |
| irq_b_no | output | 1 | Port B interrupt, active low |

## Verification
A bad arming bit shows only at the next strobe that sees an edge. It then appears either as a flag that sets when it should not, or as one that never sets; bit 7 or 6 of a control read and the irq pin expose it within one strobe. A stuck bank-select bit sends a data read to the wrong register, so the very next read returns the direction mask instead of mixed pin data. A handshake latch that fails to release keeps the second control line low past the strobe or edge that should free it. The bench samples that line immediately after each such strobe.

// File: rtl/par_io_pkg.sv
package par_io_pkg;
  localparam int unsigned CTL_W       = 6;
  localparam int unsigned CTL_C1_EN   = 0;
  localparam int unsigned CTL_C1_RISE = 1;
  localparam int unsigned CTL_BANK    = 2;
  localparam int unsigned CTL_C2_B3   = 3;
  localparam int unsigned CTL_C2_B4   = 4;
  localparam int unsigned CTL_C2_OUT  = 5;

  typedef enum logic [1:0] {
    C2_INPUT  = 2'b00,
    C2_HSHAKE = 2'b10,
    C2_FIXED  = 2'b11
  } c2_mode_e;

  function automatic c2_mode_e c2_mode(input logic [CTL_W-1:0] ctl);
    if (!ctl[CTL_C2_OUT]) return C2_INPUT;
    return ctl[CTL_C2_B4] ? C2_FIXED : C2_HSHAKE;
  endfunction
endpackage

// File: rtl/par_io_edge.sv
module par_io_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic lvl_i,
  input  logic rise_i,
  output logic hit_o
);
  logic armed_q;
  logic at_active;

  assign at_active = (lvl_i == rise_i);
  assign hit_o     = sample_i & armed_q & at_active;

  // armed only after a strobe saw the inactive level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (sample_i) armed_q <= !at_active;
  end
endmodule

// File: rtl/par_io_port.sv
module par_io_port
  import par_io_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter bit          HS_ON_WRITE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          e_i,
  input  logic          acc_i,
  input  logic          rw_i,
  input  logic          rs_ctl_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] pin_out_o,
  output logic [DW-1:0] pin_oe_o,
  input  logic          c1_i,
  input  logic          c2_i,
  output logic          c2_out_o,
  output logic          c2_oe_o,
  output logic          irq_no
);
  logic [DW-1:0]    ddr_q, or_q;
  logic [CTL_W-1:0] ctl_q;
  logic             f1_q, f2_q, hs_low_q;
  logic             c1_hit, c2_raw, c2_hit;
  logic             wr, rd, bank_or, bank_ddr, data_rd, hs_trig;
  c2_mode_e         mode;

  assign mode     = c2_mode(ctl_q);
  assign wr       = acc_i & !rw_i;
  assign rd       = acc_i & rw_i;
  assign bank_or  = !rs_ctl_i & ctl_q[CTL_BANK];
  assign bank_ddr = !rs_ctl_i & !ctl_q[CTL_BANK];
  assign data_rd  = rd & bank_or;
  assign hs_trig  = acc_i & bank_or & (rw_i != HS_ON_WRITE);

  par_io_edge u_edge1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(e_i),
    .lvl_i(c1_i), .rise_i(ctl_q[CTL_C1_RISE]), .hit_o(c1_hit)
  );
  par_io_edge u_edge2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(e_i),
    .lvl_i(c2_i), .rise_i(ctl_q[CTL_C2_B4]), .hit_o(c2_raw)
  );
  assign c2_hit = c2_raw & (mode == C2_INPUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ddr_q <= '0;
      or_q  <= '0;
      ctl_q <= '0;
    end else if (wr) begin
      if (rs_ctl_i)      ctl_q <= wdata_i[CTL_W-1:0];
      else if (bank_or)  or_q  <= wdata_i;
      else               ddr_q <= wdata_i;
    end
  end

  // a new edge wins over a clearing read in the same strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f1_q <= 1'b0;
      f2_q <= 1'b0;
    end else begin
      if (c1_hit)       f1_q <= 1'b1;
      else if (data_rd) f1_q <= 1'b0;
      if (mode != C2_INPUT) f2_q <= 1'b0;
      else if (c2_hit)      f2_q <= 1'b1;
      else if (data_rd)     f2_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hs_low_q <= 1'b0;
    else if (mode != C2_HSHAKE)   hs_low_q <= 1'b0;
    else if (hs_trig)             hs_low_q <= 1'b1;
    else if (ctl_q[CTL_C2_B3] ? e_i : c1_hit) hs_low_q <= 1'b0;
  end

  assign pin_out_o = or_q;
  assign pin_oe_o  = ddr_q;
  assign c2_oe_o   = (mode != C2_INPUT);
  assign c2_out_o  = (mode == C2_FIXED)  ? ctl_q[CTL_C2_B3] :
                     (mode == C2_HSHAKE) ? !hs_low_q : 1'b0;
  assign irq_no    = !((f1_q & ctl_q[CTL_C1_EN]) |
                       (f2_q & ctl_q[CTL_C2_B3] & (mode == C2_INPUT)));

  always_comb begin
    rdata_o = '0;
    if (rs_ctl_i) begin
      rdata_o[CTL_W-1:0] = ctl_q;
      rdata_o[DW-1]      = f1_q;
      rdata_o[DW-2]      = f2_q;
    end else if (bank_ddr) begin
      rdata_o = ddr_q;
    end else begin
      rdata_o = (or_q & ddr_q) | (pin_i & ~ddr_q);
    end
  end
endmodule

// File: rtl/par_io_adapter.sv
module par_io_adapter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs0_i,
  input  logic          cs1_i,
  input  logic          cs2_ni,
  input  logic [1:0]    rs_i,
  input  logic          rw_i,
  input  logic          e_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_in_i,
  output logic [DW-1:0] pa_out_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic          ca1_i,
  input  logic          ca2_i,
  output logic          ca2_out_o,
  output logic          ca2_oe_o,
  output logic          irq_a_no,
  input  logic [DW-1:0] pb_in_i,
  output logic [DW-1:0] pb_out_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic          cb1_i,
  input  logic          cb2_i,
  output logic          cb2_out_o,
  output logic          cb2_oe_o,
  output logic          irq_b_no
);
  localparam int unsigned NPORT = 2;

  logic          sel;
  logic [DW-1:0] p_in  [NPORT];
  logic [DW-1:0] p_out [NPORT];
  logic [DW-1:0] p_oe  [NPORT];
  logic [DW-1:0] p_rd  [NPORT];
  logic [NPORT-1:0] p_c1, p_c2, p_c2_out, p_c2_oe, p_irq_n;

  assign sel = cs0_i & cs1_i & !cs2_ni;

  assign p_in[0] = pa_in_i;
  assign p_in[1] = pb_in_i;
  assign p_c1    = {cb1_i, ca1_i};
  assign p_c2    = {cb2_i, ca2_i};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    par_io_port #(.DW(DW), .HS_ON_WRITE(g == 1)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .e_i      (e_i),
      .acc_i    (e_i & sel & (rs_i[1] == g[0])),
      .rw_i     (rw_i),
      .rs_ctl_i (rs_i[0]),
      .wdata_i  (wdata_i),
      .rdata_o  (p_rd[g]),
      .pin_i    (p_in[g]),
      .pin_out_o(p_out[g]),
      .pin_oe_o (p_oe[g]),
      .c1_i     (p_c1[g]),
      .c2_i     (p_c2[g]),
      .c2_out_o (p_c2_out[g]),
      .c2_oe_o  (p_c2_oe[g]),
      .irq_no   (p_irq_n[g])
    );
  end

  assign rdata_o   = (sel & rw_i) ? p_rd[rs_i[1]] : '0;
  assign pa_out_o  = p_out[0];
  assign pa_oe_o   = p_oe[0];
  assign pb_out_o  = p_out[1];
  assign pb_oe_o   = p_oe[1];
  assign ca2_out_o = p_c2_out[0];
  assign ca2_oe_o  = p_c2_oe[0];
  assign cb2_out_o = p_c2_out[1];
  assign cb2_oe_o  = p_c2_oe[1];
  assign irq_a_no  = p_irq_n[0];
  assign irq_b_no  = p_irq_n[1];
endmodule

// File: rtl/par_io_adapter_chk.sv
module par_io_adapter_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs0_i,
  input logic          cs1_i,
  input logic          cs2_ni,
  input logic          e_i,
  input logic [DW-1:0] pa_oe_o,
  input logic [DW-1:0] pb_oe_o,
  input logic          ca2_out_o,
  input logic          ca2_oe_o,
  input logic          cb2_oe_o,
  input logic          irq_a_no,
  input logic          irq_b_no
);
  p_hold_unselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_i && !(cs0_i && cs1_i && !cs2_ni)) |=>
      ($stable(pa_oe_o) && $stable(pb_oe_o) && $stable(ca2_oe_o) && $stable(cb2_oe_o)));

  p_irq_a_on_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_a_no) |-> $past(e_i));

  p_irq_b_on_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_b_no) |-> $past(e_i));

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (pa_oe_o == '0 && pb_oe_o == '0 && irq_a_no && irq_b_no &&
                 !ca2_oe_o && !cb2_oe_o));

  p_hshake_on_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ca2_out_o) |-> $past(e_i));
endmodule

bind par_io_adapter par_io_adapter_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs0_i(cs0_i), .cs1_i(cs1_i), .cs2_ni(cs2_ni),
  .e_i(e_i), .pa_oe_o(pa_oe_o), .pb_oe_o(pb_oe_o), .ca2_out_o(ca2_out_o),
  .ca2_oe_o(ca2_oe_o), .cb2_oe_o(cb2_oe_o), .irq_a_no(irq_a_no), .irq_b_no(irq_b_no)
);

// File: tb/par_io_adapter_bench.sv
module par_io_adapter_bench;
  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  logic rst_ni;
  logic cs0 = 0, cs1 = 0, cs2n = 1, rw = 1, e = 0;
  logic [1:0] rs = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_in = 8'h3C, pa_out, pa_oe, pb_in = 8'h5A, pb_out, pb_oe;
  logic ca1 = 0, ca2 = 0, cb1 = 0, cb2 = 0;
  logic ca2_out, ca2_oe, cb2_out, cb2_oe, irq_a_n, irq_b_n;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  par_io_adapter u_par_io_adapter (
    .clk_i(clk), .rst_ni(rst_ni), .cs0_i(cs0), .cs1_i(cs1), .cs2_ni(cs2n),
    .rs_i(rs), .rw_i(rw), .e_i(e), .wdata_i(wdata), .rdata_o(rdata),
    .pa_in_i(pa_in), .pa_out_o(pa_out), .pa_oe_o(pa_oe), .ca1_i(ca1), .ca2_i(ca2),
    .ca2_out_o(ca2_out), .ca2_oe_o(ca2_oe), .irq_a_no(irq_a_n),
    .pb_in_i(pb_in), .pb_out_o(pb_out), .pb_oe_o(pb_oe), .cb1_i(cb1), .cb2_i(cb2),
    .cb2_out_o(cb2_out), .cb2_oe_o(cb2_oe), .irq_b_no(irq_b_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic r, input logic [1:0] a, input logic [7:0] d, input logic pick);
    @(posedge clk); #1;
    cs0 = 1; cs1 = 1; cs2n = !pick; e = 1; rw = r; rs = a; wdata = d;
    @(posedge clk); #1;
    e = 0; cs0 = 0; cs1 = 0; cs2n = 1; rw = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus(1'b0, a, d, 1'b1);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b1, a, 8'h00, 1'b1);
  endtask

  task automatic tick();
    @(posedge clk); #1; e = 1;
    @(posedge clk); #1; e = 0;
  endtask

  // monitor: compares each selected read against the queued expectation
  always @(negedge clk) begin
    if (e && rw && cs0 && cs1 && !cs2n) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL monitor: actual %h expected none", rdata);
      end else begin
        automatic logic [7:0] x = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata, x);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R9 reset state
    check("R9 pa_oe", pa_oe, 8'h00);
    check("R9 irq", {6'd0, irq_a_n, irq_b_n}, 8'h03);
    check("R9 c2 oe", {6'd0, ca2_oe, cb2_oe}, 8'h00);
    rd(2'd1, 8'h00, "R9 ctl A");
    rd(2'd3, 8'h00, "R9 ctl B");

    // R2 R3 R4 map and data paths
    wr(2'd0, 8'hF0);
    check("R2 pa_oe", pa_oe, 8'hF0);
    wr(2'd1, 8'hC4);
    rd(2'd1, 8'h04, "R4 ctl upper bits read-only");
    wr(2'd0, 8'hA5);
    check("R2 pa_out", pa_out, 8'hA5);
    check("R4 ddr untouched", pa_oe, 8'hF0);
    rd(2'd0, 8'hAC, "R3 mixed read");
    wr(2'd1, 8'h00);
    rd(2'd0, 8'hF0, "R4 ddr bank");

    // R1 unselected write ignored
    bus(1'b0, 2'd0, 8'hFF, 1'b0);
    check("R1 pa_oe", pa_oe, 8'hF0);
    rd(2'd0, 8'hF0, "R1 ddr kept");

    // R5 rising edge on ca1
    wr(2'd1, 8'h07);
    tick();
    ca1 = 1; tick();
    check("R5 irq_a", {7'd0, irq_a_n}, 8'h00);
    rd(2'd1, 8'h87, "R5 flag1 rising");

    // R7 clear, then R5 falling
    wr(2'd1, 8'h05);
    tick();
    rd(2'd0, 8'hAC, "R7 data read");
    rd(2'd1, 8'h05, "R7 flag cleared");
    check("R7 irq_a high", {7'd0, irq_a_n}, 8'h01);
    ca1 = 0; tick();
    rd(2'd1, 8'h85, "R5 flag1 falling");
    check("R5 irq_a falling", {7'd0, irq_a_n}, 8'h00);

    // R10 ca2 input edge, R7 both flags cleared
    wr(2'd1, 8'h1C);
    tick();
    rd(2'd0, 8'hAC, "R7 data read");
    rd(2'd1, 8'h1C, "R7 flag cleared 2");
    ca2 = 1; tick();
    rd(2'd1, 8'h5C, "R10 flag2 rising");
    check("R8 irq from flag2", {7'd0, irq_a_n}, 8'h00);
    ca1 = 1; tick();
    ca1 = 0; tick();
    rd(2'd1, 8'hDC, "R7 both flags set");
    rd(2'd0, 8'hAC, "R7 data read");
    rd(2'd1, 8'h1C, "R7 both flags cleared");
    check("R7 irq_a high", {7'd0, irq_a_n}, 8'h01);

    // R8 flag without enable keeps irq high
    wr(2'd1, 8'h14);
    tick();
    ca2 = 0; tick();
    ca2 = 1; tick();
    rd(2'd1, 8'h54, "R8 flag2 no enable");
    check("R8 irq_a masked", {7'd0, irq_a_n}, 8'h01);
    rd(2'd0, 8'hAC, "R7 data read");

    // R11 fixed output
    wr(2'd1, 8'h38);
    check("R11 ca2 high", {6'd0, ca2_oe, ca2_out}, 8'h03);
    wr(2'd1, 8'h30);
    check("R11 ca2 low", {6'd0, ca2_oe, ca2_out}, 8'h02);

    // R12 handshake, port A on read
    wr(2'd1, 8'h24);
    check("R12 idle", {6'd0, ca2_oe, ca2_out}, 8'h03);
    rd(2'd0, 8'hAC, "R12 data read");
    check("R12 low after read", {7'd0, ca2_out}, 8'h00);
    tick();
    check("R12 held", {7'd0, ca2_out}, 8'h00);
    ca1 = 1; tick();
    check("R12 inactive edge", {7'd0, ca2_out}, 8'h00);
    ca1 = 0; tick();
    check("R12 release on edge", {7'd0, ca2_out}, 8'h01);

    // R13 pulse mode
    wr(2'd1, 8'h2C);
    rd(2'd0, 8'hAC, "R13 data read");
    check("R13 pulse low", {7'd0, ca2_out}, 8'h00);
    tick();
    check("R13 pulse end", {7'd0, ca2_out}, 8'h01);

    // R6 arming on port B: cb1 at active level since reset
    wr(2'd3, 8'h05);
    tick();
    rd(2'd3, 8'h05, "R6 no flag unarmed");
    check("R6 irq_b", {7'd0, irq_b_n}, 8'h01);
    cb1 = 1; tick();
    cb1 = 0; tick();
    rd(2'd3, 8'h85, "R6 armed edge");
    check("R5 irq_b", {7'd0, irq_b_n}, 8'h00);
    rd(2'd2, 8'h5A, "R3 all-input read");
    rd(2'd3, 8'h05, "R7 port B cleared");

    // R14 port B handshake on write
    wr(2'd3, 8'h2C);
    wr(2'd2, 8'h77);
    check("R14 low after write", {6'd0, cb2_oe, cb2_out}, 8'h02);
    check("R2 pb_out", pb_out, 8'h77);
    check("R2 pb_oe", pb_oe, 8'h00);
    tick();
    check("R14 pulse end", {7'd0, cb2_out}, 8'h01);
    rd(2'd2, 8'h5A, "R14 data read");
    check("R14 read no trigger", {7'd0, cb2_out}, 8'h01);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule